// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter Pair

This block holds two timer/counters, A and B. Each one has a low count byte, a high count byte, a run bit, a gate-enable bit, a source select and an overflow flag. The source select picks one of two inputs. The first is a machine-cycle tick, one core clock in every `TICK_DIV`. The second is falling edges on an external count pin. When gating is enabled, an external gate level must also be high before anything is counted. The overflow flags are driven straight out as interrupt requests. Each flag can be cleared by an acknowledge pulse or by software.

Each timer runs in one of four modes:
- a 13-bit counter, built from the high byte over the five low bits of the low byte;
- a full 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- split mode. Timer A in split mode becomes two independent 8-bit counters, and its high byte borrows timer B's run bit and overflow flag. Timer B in split mode freezes.

Software reaches every field through a small synchronous write port and a combinational read port. The read and write addresses are the same.

Top module: `dual_tmr_pair`

## Requirements
- R1: After reset every readable register is 0x00 and both `irq_a` and `irq_b` are low.
- R2: A timer advances only when its run bit is 1 and either its gate-enable bit is 0 or its synchronized gate pin is 1. Otherwise its count bytes stay at their values.
- R3: With source select 0, a timer advances once per machine-cycle tick. The tick comes once every `TICK_DIV` (default 12) clocks after reset is released, so any 12 consecutive clock edges give exactly one increment. Count bytes change only on tick edges or on software writes.
- R4: With source select 1, a timer advances once for each 1-to-0 transition of its count pin. The pin passes through a two-flop synchronizer and is sampled on each tick, so a level must be held for at least `2*TICK_DIV` clocks.
- R5: Mode 0 forms a 13-bit count from the high byte (upper part) and low-byte bits 4:0. Bits 7:5 of the low byte keep whatever value was written. A step from 0x1FFF to 0 sets the flag.
- R6: Mode 1 counts through all 16 bits (high:low). A step from 0xFFFF to 0x0000 sets the flag.
- R7: In mode 2 only the low byte counts. When the low byte steps past 0xFF, it is loaded from the high byte and the flag is set. Mode 2 never changes the high byte.
- R8: Timer A in mode 3 is split in two:
  - The low byte counts as an 8-bit wrap counter under A's own select, gate and run bits, and sets flag A.
  - The high byte counts machine-cycle ticks whenever B's run bit is 1, with no gating. Its wrap from 0xFF sets flag B.
- R9: Timer B in mode 3 holds both of its bytes. While A is in mode 3, B still counts in modes 0 to 2, but its own overflows no longer set flag B.
- R10: Flags are set only by hardware. A flag is cleared by its acknowledge pulse, or by a write to address 0 with that flag's bit at 0. Writing 1 to a flag bit has no effect. When a set and a clear fall in the same cycle, the flag ends up set.
- R11: Register map:
  - Address 0 holds the control bits: run A in bit 0, flag A in bit 1, run B in bit 2, flag B in bit 3.
  - Address 1 holds the configuration. Mode A is in bits 1:0, select A in bit 2 and gate-enable A in bit 3. Timer B uses bits 5:4, 6 and 7 in the same way.
  - Addresses 2 to 5 hold A low, A high, B low and B high.
  - Addresses 6 and 7 read as 0.
  - Setting a run bit leaves the counts as they are. A software write to a count byte takes precedence over a hardware step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| ack_a | input | 1 | Acknowledge pulse that clears flag A |
| ack_b | input | 1 | Acknowledge pulse that clears flag B |
| cnt_pin_a | input | 1 | External event input for timer A |
| cnt_pin_b | input | 1 | External event input for timer B |
| gate_pin_a | input | 1 | External gate level for timer A |
| gate_pin_b | input | 1 | External gate level for timer B |
| irq_a | output | 1 | Overflow flag A (interrupt request) |
| irq_b | output | 1 | Overflow flag B (interrupt request) |

## Verification
Several rules hold on every cycle and are checked by assertions:
- a stopped or gated-off timer holds its low byte;
- no count byte moves between ticks unless software writes it;
- the mode-2 high byte never changes on its own;
- a timer B parked in mode 3 stays frozen;
- a flag only falls after an acknowledge or a clearing write.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference model:
- the exact count after a known number of ticks;
- the 13-bit rollover that keeps the upper low-byte bits;
- reload values;
- falling-edge counting;
- the borrowing of B's run bit and flag in split mode;
- the set-over-clear priority.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int NTMR   = 2;
    localparam int TA     = 0;
    localparam int TB     = 1;
    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int ADDR_W = 3;
    localparam int NPIN   = 2 * NTMR;
    localparam int CTRL_STRIDE = 2;
    localparam int CFG_STRIDE  = 4;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CFG      = 3'd1;
    localparam int                ADR_CNT_BASE = 2;

    typedef enum logic [1:0] {
        MODE_13     = 2'd0,
        MODE_16     = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_SPLIT  = 2'd3
    } tmr_mode_e;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t     [NTMR-1:0] lo;
        byte_t     [NTMR-1:0] hi;
        logic      [NTMR-1:0] run;
        logic      [NTMR-1:0] flag;
        logic      [NTMR-1:0] sel;
        logic      [NTMR-1:0] gate;
        logic      [NTMR-1:0] last_cnt;
        tmr_mode_e [NTMR-1:0] mode;
    } tmr_state_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int t);
        return ADDR_W'(ADR_CNT_BASE + 2 * t);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int t);
        return ADDR_W'(ADR_CNT_BASE + 2 * t + 1);
    endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = tick_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = pins_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tmr_step.sv
`timescale 1ns/1ps
module tmr_step
    import tmr_pkg::*;
(
    input  tmr_mode_e mode_i,
    input  byte_t     lo_i,
    input  byte_t     hi_i,
    input  logic      inc_i,
    output byte_t     lo_o,
    output byte_t     hi_o,
    output logic      ovf_o
);
    localparam int W13 = BYTE_W + PRE_W + 1;
    localparam int W16 = 2 * BYTE_W + 1;

    logic [W13-1:0] sum13;
    logic [W16-1:0] sum16;

    always_comb begin
        lo_o  = lo_i;
        hi_o  = hi_i;
        ovf_o = 1'b0;
        sum13 = {1'b0, hi_i, lo_i[PRE_W-1:0]} + W13'(1);
        sum16 = {1'b0, hi_i, lo_i} + W16'(1);
        if (inc_i) begin
            unique case (mode_i)
                MODE_13: begin
                    lo_o[PRE_W-1:0] = sum13[PRE_W-1:0];
                    hi_o            = sum13[PRE_W +: BYTE_W];
                    ovf_o           = sum13[W13-1];
                end
                MODE_16: begin
                    lo_o  = sum16[BYTE_W-1:0];
                    hi_o  = sum16[BYTE_W +: BYTE_W];
                    ovf_o = sum16[W16-1];
                end
                MODE_RELOAD: begin
                    if (&lo_i) begin
                        lo_o  = hi_i;
                        ovf_o = 1'b1;
                    end else begin
                        lo_o = lo_i + byte_t'(1);
                    end
                end
                MODE_SPLIT: begin
                    lo_o  = lo_i + byte_t'(1);
                    ovf_o = &lo_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/dual_tmr_pair.sv
`timescale 1ns/1ps
module dual_tmr_pair
    import tmr_pkg::*;
#(
    parameter int TICK_DIV = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ack_a,
    input  logic              ack_b,
    input  logic              cnt_pin_a,
    input  logic              cnt_pin_b,
    input  logic              gate_pin_a,
    input  logic              gate_pin_b,
    output logic              irq_a,
    output logic              irq_b
);
    tmr_state_t st_d, st_q;

    logic             tick;
    logic [NPIN-1:0]  pin_s;
    logic [NTMR-1:0]  ev, inc, ack, set_flag, clr_flag;
    byte_t [NTMR-1:0] step_lo, step_hi;
    logic [NTMR-1:0]  step_ovf;
    logic             split, hi_tick, hi_wrap, wr_ctrl, wr_cfg;

    tmr_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_pin_sync #(.N(NPIN), .STAGES(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({gate_pin_b, gate_pin_a, cnt_pin_b, cnt_pin_a}),
        .sync_o (pin_s)
    );

    assign ack = {ack_b, ack_a};

    // Count enables: run, gate and source selection per timer
    always_comb begin
        for (int t = 0; t < NTMR; t++) begin
            ev[t]  = tick && st_q.last_cnt[t] && !pin_s[t];
            inc[t] = st_q.run[t] && (!st_q.gate[t] || pin_s[NTMR+t])
                     && (st_q.sel[t] ? ev[t] : tick);
        end
        if (st_q.mode[TB] == MODE_SPLIT) inc[TB] = 1'b0;
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_step
        tmr_step i_step (
            .mode_i (st_q.mode[t]),
            .lo_i   (st_q.lo[t]),
            .hi_i   (st_q.hi[t]),
            .inc_i  (inc[t]),
            .lo_o   (step_lo[t]),
            .hi_o   (step_hi[t]),
            .ovf_o  (step_ovf[t])
        );
    end

    // Next-state computation
    always_comb begin
        st_d    = st_q;
        split   = (st_q.mode[TA] == MODE_SPLIT);
        hi_tick = split && tick && st_q.run[TB];
        hi_wrap = hi_tick && (&st_q.hi[TA]);
        wr_ctrl = reg_we && (reg_addr == ADR_CTRL);
        wr_cfg  = reg_we && (reg_addr == ADR_CFG);

        for (int t = 0; t < NTMR; t++) begin
            st_d.lo[t] = step_lo[t];
            st_d.hi[t] = step_hi[t];
        end
        if (hi_tick) st_d.hi[TA] = st_q.hi[TA] + byte_t'(1);

        set_flag[TA] = step_ovf[TA];
        set_flag[TB] = split ? hi_wrap : step_ovf[TB];

        for (int t = 0; t < NTMR; t++) begin
            clr_flag[t]  = ack[t] || (wr_ctrl && !reg_wdata[CTRL_STRIDE*t+1]);
            st_d.flag[t] = set_flag[t] || (st_q.flag[t] && !clr_flag[t]);
            if (tick) st_d.last_cnt[t] = pin_s[t];
            if (wr_ctrl) st_d.run[t] = reg_wdata[CTRL_STRIDE*t];
            if (wr_cfg) begin
                st_d.mode[t] = tmr_mode_e'(reg_wdata[CFG_STRIDE*t +: 2]);
                st_d.sel[t]  = reg_wdata[CFG_STRIDE*t+2];
                st_d.gate[t] = reg_wdata[CFG_STRIDE*t+3];
            end
            if (reg_we && reg_addr == lo_addr(t)) st_d.lo[t] = reg_wdata;
            if (reg_we && reg_addr == hi_addr(t)) st_d.hi[t] = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int t = 0; t < NTMR; t++) begin
            if (reg_addr == ADR_CTRL) begin
                reg_rdata[CTRL_STRIDE*t]   = st_q.run[t];
                reg_rdata[CTRL_STRIDE*t+1] = st_q.flag[t];
            end
            if (reg_addr == ADR_CFG) begin
                reg_rdata[CFG_STRIDE*t +: 2] = st_q.mode[t];
                reg_rdata[CFG_STRIDE*t+2]    = st_q.sel[t];
                reg_rdata[CFG_STRIDE*t+3]    = st_q.gate[t];
            end
            if (reg_addr == lo_addr(t)) reg_rdata = st_q.lo[t];
            if (reg_addr == hi_addr(t)) reg_rdata = st_q.hi[t];
        end
    end

    assign irq_a = st_q.flag[TA];
    assign irq_b = st_q.flag[TB];
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input tmr_state_t        st,
    input logic              tick,
    input logic [NPIN-1:0]   pin_s,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              ack_a,
    input logic              ack_b,
    input logic              irq_a,
    input logic              irq_b
);
    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.run[TA] && !(reg_we && reg_addr == lo_addr(TA))) |=> $stable(st.lo[TA]));

    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.gate[TA] && !pin_s[NTMR+TA] && !(reg_we && reg_addr == lo_addr(TA)))
        |=> $stable(st.lo[TA]));

    // R3
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reg_we) |=> ($stable(st.lo) && $stable(st.hi)));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7
    reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.mode[TA] == MODE_RELOAD && !(reg_we && reg_addr == hi_addr(TA)))
        |=> $stable(st.hi[TA]));

    // R9
    b_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.mode[TB] == MODE_SPLIT
         && !(reg_we && (reg_addr == lo_addr(TB) || reg_addr == hi_addr(TB))))
        |=> ($stable(st.lo[TB]) && $stable(st.hi[TB])));

    // R10
    irq_a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_a) |-> $past(ack_a || (reg_we && reg_addr == ADR_CTRL && !reg_wdata[1])));

    // R10
    irq_b_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_b) |-> $past(ack_b || (reg_we && reg_addr == ADR_CTRL && !reg_wdata[3])));
endmodule

bind dual_tmr_pair tmr_pair_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_q),
    .tick      (tick),
    .pin_s     (pin_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ack_a     (ack_a),
    .ack_b     (ack_b),
    .irq_a     (irq_a),
    .irq_b     (irq_b)
);

// File: tb/test_dual_tmr_pair.sv
`timescale 1ns/1ps
module test_dual_tmr_pair;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack_a = 1'b0, ack_b = 1'b0;
    logic       cnt_pin_a = 1'b0, cnt_pin_b = 1'b0;
    logic       gate_pin_a = 1'b0, gate_pin_b = 1'b0;
    logic       irq_a, irq_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_tmr_pair #(.TICK_DIV(DIV)) i_dual_tmr_pair (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_a(ack_a), .ack_b(ack_b),
        .cnt_pin_a(cnt_pin_a), .cnt_pin_b(cnt_pin_b), .gate_pin_a(gate_pin_a),
        .gate_pin_b(gate_pin_b), .irq_a(irq_a), .irq_b(irq_b)
    );

    // Reference model built from the requirements
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    bit   m_run[2], m_flag[2], m_sel[2], m_gate[2], m_last[2];
    int   m_mode[2];
    int   m_pre;
    bit   m_s1[4], m_s2[4];
    bit   tk, ev0, ev1, inc0, inc1, ov0, ov1, hov, wctl, clr0, clr1;
    logic [7:0] lo0, hi0, lo1, hi1;

    function automatic void step(input int mode, input bit inc,
                                 inout logic [7:0] lo, inout logic [7:0] hi,
                                 output bit ovf);
        logic [13:0] v13;
        logic [16:0] v16;
        ovf = 1'b0;
        if (!inc) return;
        case (mode)
            0: begin
                v13 = {1'b0, hi, lo[4:0]} + 14'd1;
                ovf = v13[13]; hi = v13[12:5]; lo[4:0] = v13[4:0];
            end
            1: begin
                v16 = {1'b0, hi, lo} + 17'd1;
                ovf = v16[16]; {hi, lo} = v16[15:0];
            end
            2: begin
                if (lo == 8'hFF) begin lo = hi; ovf = 1'b1; end
                else lo = lo + 8'd1;
            end
            default: begin ovf = (lo == 8'hFF); lo = lo + 8'd1; end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 2; t++) begin
                m_lo[t] = 0; m_hi[t] = 0; m_run[t] = 0; m_flag[t] = 0;
                m_sel[t] = 0; m_gate[t] = 0; m_last[t] = 0; m_mode[t] = 0;
            end
            for (int p = 0; p < 4; p++) begin m_s1[p] = 0; m_s2[p] = 0; end
            m_pre = 0;
        end else begin
            tk   = (m_pre == DIV - 1);
            ev0  = tk && m_last[0] && !m_s2[0];
            ev1  = tk && m_last[1] && !m_s2[1];
            inc0 = m_run[0] && (!m_gate[0] || m_s2[2]) && (m_sel[0] ? ev0 : tk);
            inc1 = m_run[1] && (!m_gate[1] || m_s2[3]) && (m_sel[1] ? ev1 : tk)
                   && (m_mode[1] != 3);
            lo0 = m_lo[0]; hi0 = m_hi[0]; lo1 = m_lo[1]; hi1 = m_hi[1];
            step(m_mode[0], inc0, lo0, hi0, ov0);
            step(m_mode[1], inc1, lo1, hi1, ov1);
            hov = 1'b0;
            if (m_mode[0] == 3 && tk && m_run[1]) begin
                hov = (hi0 == 8'hFF); hi0 = hi0 + 8'd1;
            end
            wctl = reg_we && reg_addr == 3'd0;
            clr0 = ack_a || (wctl && !reg_wdata[1]);
            clr1 = ack_b || (wctl && !reg_wdata[3]);
            m_flag[0] = ov0 || (m_flag[0] && !clr0);
            m_flag[1] = ((m_mode[0] == 3) ? hov : ov1) || (m_flag[1] && !clr1);
            if (wctl) begin m_run[0] = reg_wdata[0]; m_run[1] = reg_wdata[2]; end
            if (reg_we && reg_addr == 3'd1) begin
                m_mode[0] = int'(reg_wdata[1:0]); m_sel[0] = reg_wdata[2]; m_gate[0] = reg_wdata[3];
                m_mode[1] = int'(reg_wdata[5:4]); m_sel[1] = reg_wdata[6]; m_gate[1] = reg_wdata[7];
            end
            if (reg_we && reg_addr == 3'd2) lo0 = reg_wdata;
            if (reg_we && reg_addr == 3'd3) hi0 = reg_wdata;
            if (reg_we && reg_addr == 3'd4) lo1 = reg_wdata;
            if (reg_we && reg_addr == 3'd5) hi1 = reg_wdata;
            m_lo[0] = lo0; m_hi[0] = hi0; m_lo[1] = lo1; m_hi[1] = hi1;
            if (tk) begin m_last[0] = m_s2[0]; m_last[1] = m_s2[1]; end
            for (int p = 0; p < 4; p++) m_s2[p] = m_s1[p];
            m_s1[0] = cnt_pin_a; m_s1[1] = cnt_pin_b; m_s1[2] = gate_pin_a; m_s1[3] = gate_pin_b;
            m_pre = tk ? 0 : m_pre + 1;
        end
    end

    function automatic logic [7:0] exp_reg(input int a);
        case (a)
            0: return {4'b0, m_flag[1], m_run[1], m_flag[0], m_run[0]};
            1: return {m_gate[1], m_sel[1], 2'(m_mode[1]), m_gate[0], m_sel[0], 2'(m_mode[0])};
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        cmp(tag, $sformatf("addr%0d", a), v, exp);
    endtask

    // Compare every readable register and both flags against the model
    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            expect_reg(tag, 3'(a), exp_reg(a));
        end
        cmp(tag, "irq_a", {7'b0, irq_a}, {7'b0, m_flag[0]});
        cmp(tag, "irq_b", {7'b0, irq_b}, {7'b0, m_flag[1]});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        void'($urandom(32'd4242));
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) expect_reg("R1", 3'(a), 8'h00);
        cmp("R1", "irq_a", {7'b0, irq_a}, 8'h00);
        cmp("R1", "irq_b", {7'b0, irq_b}, 8'h00);

        // R11 run bit does not clear; R6 16-bit rollover
        wr(3'd2, 8'hF0); wr(3'd3, 8'hFF); wr(3'd1, 8'h01); wr(3'd0, 8'h01);
        expect_reg("R11", 3'd2, 8'hF0);
        expect_reg("R11", 3'd3, 8'hFF);
        wait_cyc(17 * DIV);
        expect_reg("R6", 3'd2, 8'h01);
        expect_reg("R6", 3'd3, 8'h00);
        cmp("R6", "irq_a", {7'b0, irq_a}, 8'h01);

        // R10 acknowledge clears, writing 1 to flag bit has no effect
        @(negedge clk); ack_a = 1'b1; @(negedge clk); ack_a = 1'b0;
        cmp("R10", "irq_a ack", {7'b0, irq_a}, 8'h00);
        wr(3'd0, 8'h02);
        cmp("R10", "irq_a w1", {7'b0, irq_a}, 8'h00);
        check_all("R10");

        // R5 13-bit mode keeps low-byte bits 7:5, exactly 3 ticks in 36 clocks (R3)
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h00); wr(3'd0, 8'h01);
        wait_cyc(3 * DIV);
        expect_reg("R5", 3'd2, 8'hE1);
        expect_reg("R5", 3'd3, 8'h00);
        cmp("R5", "irq_a", {7'b0, irq_a}, 8'h01);

        // R7 reload mode
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h80); wr(3'd2, 8'hFD); wr(3'd1, 8'h02); wr(3'd0, 8'h01);
        wait_cyc(3 * DIV);
        expect_reg("R7", 3'd2, 8'h80);
        expect_reg("R7", 3'd3, 8'h80);
        cmp("R7", "irq_a", {7'b0, irq_a}, 8'h01);
        expect_reg("R3", 3'd2, 8'h80);

        // R2 gating by external pin
        wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        gate_pin_a = 1'b0;
        wr(3'd1, 8'h09); wr(3'd0, 8'h01);
        wait_cyc(5 * DIV);
        expect_reg("R2", 3'd2, 8'h00);
        gate_pin_a = 1'b1;
        wait_cyc(10 * DIV);
        check_all("R2");

        // R4 event counting on falling edges
        wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h05);
        cnt_pin_a = 1'b0;
        wr(3'd0, 8'h01);
        for (int k = 0; k < 5; k++) begin
            cnt_pin_a = 1'b1; wait_cyc(30);
            cnt_pin_a = 1'b0; wait_cyc(30);
        end
        expect_reg("R4", 3'd2, 8'h05);
        check_all("R4");

        // R8 split mode: A high byte uses B's run and flag; R9 B keeps counting
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00); wr(3'd3, 8'hFE); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h13); wr(3'd0, 8'h05);
        wait_cyc(3 * DIV);
        expect_reg("R8", 3'd2, 8'h03);
        expect_reg("R8", 3'd3, 8'h01);
        cmp("R8", "irq_b", {7'b0, irq_b}, 8'h01);
        expect_reg("R9", 3'd4, 8'h03);
        wr(3'd0, 8'h05);
        cmp("R10", "irq_b clear", {7'b0, irq_b}, 8'h00);

        // R9 B in mode 3 freezes, A high continues under B's run bit (R8)
        wr(3'd1, 8'h33);
        rd(3'd4, v); rd(3'd3, v2);
        wait_cyc(3 * DIV);
        expect_reg("R9", 3'd4, v);
        expect_reg("R8", 3'd3, v2 + 8'd3);
        check_all("R9");
        wr(3'd0, 8'h00);

        // Random phase (all requirements, set-over-clear of R10 included)
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            reg_we = 1'b0; ack_a = 1'b0; ack_b = 1'b0;
            if (i % 8 == 0) check_all("R10");
            if ($urandom % 16 == 0) cnt_pin_a = ~cnt_pin_a;
            if ($urandom % 16 == 0) cnt_pin_b = ~cnt_pin_b;
            if ($urandom % 64 == 0) gate_pin_a = ~gate_pin_a;
            if ($urandom % 64 == 0) gate_pin_b = ~gate_pin_b;
            if ($urandom % 40 == 0) ack_a = 1'b1;
            if ($urandom % 40 == 0) ack_b = 1'b1;
            if ($urandom % 12 == 0) begin
                reg_we    = 1'b1;
                reg_addr  = 3'($urandom % 8);
                reg_wdata = 8'($urandom);
                if (reg_addr >= 3'd2 && ($urandom % 2 == 0)) reg_wdata = reg_wdata | 8'hF8;
                if (reg_addr == 3'd0 && ($urandom % 2 == 0)) reg_wdata = reg_wdata | 8'h05;
            end
        end
        @(negedge clk);
        reg_we = 1'b0; ack_a = 1'b0; ack_b = 1'b0;
        check_all("R11");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule